// File: doc/BRIEF.md
# Timer Interrupt Flag and Enable Unit

This block keeps the pending-event flags and the per-source interrupt enables of one timer/counter. Four event strobes feed it: counter overflow, compare match A, compare match B and input capture. Each strobe latches a sticky flag. Software reaches both registers over a byte-wide register port. A flag clears in two ways: software writes a one to its bit, or the interrupt controller pulses the acknowledge line for that source when it takes the vector.

One request line per source goes to the interrupt controller. A request is raised only when the source's flag is set, its enable bit is set and the global interrupt enable input is high. The request lines and the read-data bus are registered. The counter, the capture edge logic and vector priority live outside this block.

Top module: `tmr_irq_unit`

## Requirements
- R1: After a synchronous reset, the flag register, the enable register and all request outputs are zero.
- R2: The bit layout is the same in both registers: bit 0 is overflow, bit 1 is compare A, bit 2 is compare B and bit 3 is capture. The event strobe on `evt_in[i]` sets flag bit i at the next clock edge.
- R3: A write to address 0 (flag register) clears every flag whose data bit is one. Flags whose data bit is zero keep their value.
- R4: A pulse on `ack_in[i]` clears flag bit i at the next clock edge.
- R5: If an event strobe arrives in the same cycle as a software clear or an acknowledge for the same bit, the flag ends up set.
- R6: A write to address 1 (enable register) loads data bits 3..0 into the enables. Reading address 1 returns them.
- R7: Bits 7..4 of both registers always read zero, and writing ones to them has no effect.
- R8: `irq_out[i]` is high exactly one cycle after a cycle in which flag i, enable i and `gie_in` were all high.
- R9: A read returns the register value at the clock edge where the read is accepted, with `rdata` valid after that edge. Reads have no side effect on flags or enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = flag register, 1 = enable register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| gie_in | input | 1 | Global interrupt enable |
| evt_in | input | 4 | Single-cycle event strobes (bit 0 overflow .. bit 3 capture) |
| ack_in | input | 4 | Vector acknowledge, one per source |
| irq_out | output | 4 | Registered interrupt requests |

## Verification
A flag stuck high or lost shows up twice at the ports. The request line for that source goes wrong two edges after the causing input, once its enable and the global enable are set. A read of address 0 shows it one edge after the read is accepted. A corrupted enable bit shows in the same ways: through the gated request and through a read of address 1. The bench walks every flag pattern against every clear pattern, and every enable pattern against both settings of the global enable. It also forces set/clear collisions on each bit, so any single-bit fault appears within a few cycles.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int unsigned SRC_N  = 4;
  localparam int unsigned BYTE_W = 8;
  localparam logic ADDR_FLAG = 1'b0;
  localparam logic ADDR_MASK = 1'b1;
  typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/tmr_irq_flag_bank.sv
module tmr_irq_flag_bank #(
  parameter int unsigned NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] sw_clr_i,
  input  logic [NSRC-1:0] hw_clr_i,
  output logic [NSRC-1:0] flag_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= 1'b0;
      else if (set_i[i])
        q <= 1'b1;
      else if (sw_clr_i[i] || hw_clr_i[i])
        q <= 1'b0;
    end
    assign flag_o[i] = q;

    // R5 and R2: a strobe always leaves the flag set
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> flag_o[i]);
    // R3 and R4: any clear without a strobe empties the flag
    assert_clear_R3_R4: assert property (@(posedge clk) disable iff (rst)
      (!set_i[i] && (sw_clr_i[i] || hw_clr_i[i])) |=> !flag_o[i]);
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (!set_i[i] && !sw_clr_i[i] && !hw_clr_i[i]) |=> $stable(flag_o[i]));
  end
endmodule

// File: rtl/tmr_irq_mask_reg.sv
module tmr_irq_mask_reg #(
  parameter int unsigned NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [NSRC-1:0] data_i,
  output logic [NSRC-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (rst)
      mask_o <= '0;
    else if (load_i)
      mask_o <= data_i;
  end

  assert_mask_load_R6: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (mask_o == $past(data_i)));
  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(mask_o));
endmodule

// File: rtl/tmr_irq_req_gate.sv
module tmr_irq_req_gate #(
  parameter int unsigned NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            gie_i,
  input  logic [NSRC-1:0] flag_i,
  input  logic [NSRC-1:0] mask_i,
  output logic [NSRC-1:0] irq_o
);
  always_ff @(posedge clk) begin
    if (rst)
      irq_o <= '0;
    else
      irq_o <= (flag_i & mask_i) & {NSRC{gie_i}};
  end

  assert_gie_gates_R8: assert property (@(posedge clk) disable iff (rst)
    !gie_i |=> (irq_o == '0));
  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    assert_req_source_R8: assert property (@(posedge clk) disable iff (rst)
      (flag_i[i] && mask_i[i] && gie_i) |=> irq_o[i]);
  end
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
  import tmr_irq_pkg::*;
#(
  parameter int unsigned NSRC = SRC_N,
  parameter int unsigned DW   = BYTE_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic            bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            gie_in,
  input  logic [NSRC-1:0] evt_in,
  input  logic [NSRC-1:0] ack_in,
  output logic [NSRC-1:0] irq_out
);
  localparam int unsigned PAD_W = DW - NSRC;

  logic            wr_flag, wr_mask, rd_en;
  logic [NSRC-1:0] flags, mask, sw_clr;

  assign wr_flag = bus_sel && bus_wr && (bus_addr == ADDR_FLAG);
  assign wr_mask = bus_sel && bus_wr && (bus_addr == ADDR_MASK);
  assign rd_en   = bus_sel && !bus_wr;
  assign sw_clr  = wr_flag ? bus_wdata[NSRC-1:0] : '0;

  tmr_irq_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk(clk), .rst(rst), .set_i(evt_in), .sw_clr_i(sw_clr),
    .hw_clr_i(ack_in), .flag_o(flags));

  tmr_irq_mask_reg #(.NSRC(NSRC)) u_mask (
    .clk(clk), .rst(rst), .load_i(wr_mask),
    .data_i(bus_wdata[NSRC-1:0]), .mask_o(mask));

  tmr_irq_req_gate #(.NSRC(NSRC)) u_gate (
    .clk(clk), .rst(rst), .gie_i(gie_in), .flag_i(flags),
    .mask_i(mask), .irq_o(irq_out));

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (rd_en)
      bus_rdata <= {{PAD_W{1'b0}}, (bus_addr == ADDR_MASK) ? mask : flags};
  end

  assert_read_no_side_effect_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (evt_in == '0) && (ack_in == '0)) |=> ($stable(flags) && $stable(mask)));
  assert_read_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bus_addr == ADDR_FLAG) |=> (bus_rdata[NSRC-1:0] == $past(flags)));
endmodule

// File: tb/sim_tmr_irq_unit.sv
module sim_tmr_irq_unit;
  logic       clk = 1'b0;
  logic       rst;
  logic       bus_sel, bus_wr, bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       gie_in;
  logic [3:0] evt_in, ack_in, irq_out;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tmr_irq_unit u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gie_in(gie_in), .evt_in(evt_in), .ack_in(ack_in), .irq_out(irq_out));

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bwr(logic a, logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic brd(logic a, output logic [7:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    tick();
    d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic pulse_evt(logic [3:0] e);
    evt_in = e; tick(); evt_in = '0;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    rst = 1; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    gie_in = 0; evt_in = 0; ack_in = 0;
    @(negedge clk); tick(); tick();
    rst = 0;
    // R1 reset state
    chk("R1 irq", {4'h0, irq_out}, 8'h00);
    brd(0, rd); chk("R1 flags", rd, 8'h00);
    brd(1, rd); chk("R1 mask", rd, 8'h00);

    // R2 each strobe sets its own bit
    for (int i = 0; i < 4; i++) begin
      pulse_evt(4'(1 << i));
      brd(0, rd); chk("R2 single bit", rd, 8'(1 << i));
      bwr(0, 8'hFF);
    end

    // R3 W1C exhaustive, R9 repeated read, R7 upper bits
    for (int f = 0; f < 16; f++) begin
      for (int w = 0; w < 16; w++) begin
        bwr(0, 8'h0F);
        if (f != 0) pulse_evt(4'(f));
        bwr(0, 8'(w) | 8'hF0);
        brd(0, rd); chk("R3 w1c", rd, 8'(f & ~w & 15));
        brd(0, rd); chk("R9 reread", rd, 8'(f & ~w & 15));
      end
    end

    // R4 acknowledge per bit
    for (int i = 0; i < 4; i++) begin
      pulse_evt(4'hF);
      ack_in = 4'(1 << i); tick(); ack_in = 0;
      brd(0, rd); chk("R4 ack", rd, 8'(15 & ~(1 << i)));
      bwr(0, 8'h0F);
    end

    // R5 set beats clear
    for (int i = 0; i < 4; i++) begin
      evt_in = 4'(1 << i); ack_in = 4'hF; tick(); evt_in = 0; ack_in = 0;
      brd(0, rd); chk("R5 evt vs ack", rd, 8'(1 << i));
      evt_in = 4'(1 << i);
      bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 8'hFF;
      tick();
      evt_in = 0; bus_sel = 0; bus_wr = 0;
      brd(0, rd); chk("R5 evt vs w1c", rd, 8'(1 << i));
      bwr(0, 8'h0F);
    end

    // R6, R7 enable register
    bwr(1, 8'hFF); brd(1, rd); chk("R7 mask upper", rd, 8'h0F);
    bwr(1, 8'hA5); brd(1, rd); chk("R6 mask", rd, 8'h05);

    // R8 gating sweep with all flags set
    pulse_evt(4'hF);
    for (int m = 0; m < 16; m++) begin
      for (int g = 0; g < 2; g++) begin
        bwr(1, 8'(m));
        gie_in = g[0];
        tick(); tick();
        chk("R8 irq", {4'h0, irq_out}, 8'(g ? m : 0));
      end
    end

    // R8 one-cycle latency after a strobe
    bwr(0, 8'h0F); bwr(1, 8'h0F); gie_in = 1; tick();
    chk("R8 idle", {4'h0, irq_out}, 8'h00);
    evt_in = 4'h4; tick(); evt_in = 0;
    chk("R8 not yet", {4'h0, irq_out}, 8'h00);
    tick();
    chk("R8 raised", {4'h0, irq_out}, 8'h04);
    ack_in = 4'h4; tick(); ack_in = 0; tick();
    chk("R8 dropped", {4'h0, irq_out}, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule